// File: doc/BRIEF.md
# RTC Interrupt Flag Controller

This block holds the status and control bytes that decide when a real-time clock interrupts the host. Three event pulses come in from timing logic elsewhere: a periodic tick, an alarm match and an update-ended event. Each pulse is latched into a flag byte whether or not its source is enabled, so software can poll for it. Each flag is masked with its enable bit in the control byte, and a level interrupt line results. Software clears the flag byte, and with it the interrupt, by reading it.

The host reaches the register file through two byte ports. The even port (`host_port` = 0) takes a register index. The odd port (`host_port` = 1) reads or writes the register that index selects. The rate byte sits at index 10, the control byte at 11, the flag byte at 12 and the fourth status byte at 13. All other in-range indices are plain storage.

The interrupt line is a two-state machine. `IRQ_QUIET` moves to `IRQ_RAISED` on the transition *raise*: after the cycle's updates, some latched flag has its enable set. `IRQ_RAISED` returns to `IRQ_QUIET` on the transition *acknowledge*: the flag byte is read and no enabled event arrives in the same cycle. In every other case the state holds. The summary bit of the flag byte shows the state.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset the rate byte reads 0x26, the control byte reads 0x02 (24-hour mode only), the flag byte reads 0x00, the fourth status byte reads 0x80 (valid-RAM bit) and `irq` is low.
- R2: An index-port write keeps only `host_wdata[6:0]` as the index. An index-port read returns 0xFF with `host_hit` high.
- R3: With an index of 14 or more, a data access has `host_hit` low, a data read returns 0xFF and a data write changes nothing. An index-port write of such a value also has `host_hit` low.
- R4: Pulses on `tick_evt`, `alarm_evt` and `update_evt` set flag bits 6, 5 and 4 of the flag byte even when their enables are clear, and then `irq` stays low.
- R5: When a latched flag has its enable set, the flag byte's bit 7 reads 1 and `irq` rises at the clock edge that latches the event. The enables are control bits 6 (periodic), 5 (alarm) and 4 (update).
- R6: A data read of the flag byte returns its current value, then clears all of its bits and drops `irq`.
- R7: Data writes to the flag byte and to the fourth status byte are ignored.
- R8: A control-byte write that enables a source whose flag is already latched raises `irq` at the edge of that same write.
- R9: Rate byte bit 7 (update in progress) shows `uip_in` as registered one cycle earlier. A host write cannot change it. Bits 6:0 take the written value.
- R10: If a flag-byte read and an event pulse happen in the same cycle, the new event's flag is set after the clear, and `irq` is raised if that event is enabled.
- R11: Plain storage indices (0 to 9) read back the last byte written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_port | input | 1 | 0 = index port, 1 = data port |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid while `host_sel` is high |
| host_hit | output | 1 | Access handled |
| tick_evt | input | 1 | Periodic tick pulse |
| alarm_evt | input | 1 | Alarm match pulse |
| update_evt | input | 1 | Update-ended pulse |
| uip_in | input | 1 | Live update-in-progress status |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that each host access lasts exactly one cycle with `host_sel` high. Read data is combinational and is used only in that cycle. Event inputs are single-cycle pulses that may coincide with any access. The bench drives every access and pulse as a one-cycle strobe from posedge to posedge, with at least one idle cycle between accesses. Exactly one directed case puts a pulse in the same cycle as a flag-byte read, which exercises the ordering that R10 fixes.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned IDX_W    = DATA_W - 1;
    localparam int unsigned EV_N     = 3;

    // status byte positions, decoded by host software
    localparam int unsigned IX_RATE  = 10;
    localparam int unsigned IX_CTRL  = 11;
    localparam int unsigned IX_FLAG  = 12;
    localparam int unsigned IX_STATD = 13;

    localparam int unsigned FLG_SUM  = 7;
    localparam int unsigned EV_LSB   = 4;   // periodic 6, alarm 5, update 4
    localparam int unsigned CTL_24H  = 1;

    localparam logic [DATA_W-1:0] RATE_RST  = 8'h26;
    localparam logic [DATA_W-1:0] CTRL_RST  = 8'h02;
    localparam logic [DATA_W-1:0] STATD_VAL = 8'h80;
    localparam logic [DATA_W-1:0] NO_DATA   = 8'hFF;

    typedef enum logic {IRQ_QUIET, IRQ_RAISED} irq_state_t;
endpackage

// File: rtl/rtc_host_decode.sv
module rtc_host_decode
    import rtc_irq_pkg::*;
#(
    parameter int unsigned NUM_REGS = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic              port,
    input  logic [DATA_W-1:0] wdata,
    output logic [IDX_W-1:0]  idx,
    output logic              in_range,
    output logic              data_wr,
    output logic              data_rd,
    output logic              hit
);
    localparam int unsigned CMP_W = IDX_W + 1;
    localparam logic [CMP_W-1:0] LIMIT = CMP_W'(NUM_REGS);

    logic idx_wr;
    logic new_ok;

    assign idx_wr   = sel && wr && !port;
    assign in_range = {1'b0, idx} < LIMIT;
    assign new_ok   = {1'b0, wdata[IDX_W-1:0]} < LIMIT;
    assign data_wr  = sel && wr && port && in_range;
    assign data_rd  = sel && !wr && port && in_range;

    always_ff @(posedge clk) begin
        if (!rst_n)      idx <= '0;
        else if (idx_wr) idx <= wdata[IDX_W-1:0];
    end

    always_comb begin
        hit = 1'b0;
        if (sel) begin
            if (!port) hit = wr ? new_ok : 1'b1;
            else       hit = in_range;
        end
    end

    p_index_low7_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (idx == $past(wdata[IDX_W-1:0])));
endmodule

// File: rtl/rtc_reg_store.sv
module rtc_reg_store
    import rtc_irq_pkg::*;
#(
    parameter int unsigned NUM_REGS = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              uip_in,
    output logic [DATA_W-1:0] rd_byte,
    output logic [DATA_W-1:0] ctrl
);
    localparam int unsigned FLAT_W = NUM_REGS * DATA_W;

    logic [FLAT_W-1:0]  ram_flat;
    logic [DATA_W-2:0]  rate_lo;
    logic               uip_q;
    logic [DATA_W-1:0]  rate;

    assign rate = {uip_q, rate_lo};

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
        if (i == IX_RATE || i == IX_CTRL || i == IX_FLAG || i == IX_STATD) begin : g_status
            assign ram_flat[i*DATA_W +: DATA_W] = '0;
        end else begin : g_plain
            logic [DATA_W-1:0] cell_q;
            always_ff @(posedge clk) begin
                if (!rst_n)                               cell_q <= '0;
                else if (data_wr && idx == IDX_W'(i))     cell_q <= wdata;
            end
            assign ram_flat[i*DATA_W +: DATA_W] = cell_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_lo <= RATE_RST[DATA_W-2:0];
            uip_q   <= 1'b0;
            ctrl    <= CTRL_RST;
        end else begin
            uip_q <= uip_in;
            if (data_wr && idx == IDX_W'(IX_RATE)) rate_lo <= wdata[DATA_W-2:0];
            if (data_wr && idx == IDX_W'(IX_CTRL)) ctrl    <= wdata;
        end
    end

    always_comb begin
        unique case (int'(idx))
            IX_RATE:  rd_byte = rate;
            IX_CTRL:  rd_byte = ctrl;
            IX_STATD: rd_byte = STATD_VAL;
            default:  rd_byte = (int'(idx) < NUM_REGS) ? ram_flat[int'(idx)*DATA_W +: DATA_W] : '0;
        endcase
    end

    p_uip_readonly_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && idx == IDX_W'(IX_RATE)) |=>
            (rate[DATA_W-1] == $past(uip_in) && rate[DATA_W-2:0] == $past(wdata[DATA_W-2:0])));
endmodule

// File: rtl/rtc_flag_fsm.sv
module rtc_flag_fsm
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EV_N-1:0]   ev,        // {periodic, alarm, update}
    input  logic [EV_N-1:0]   en_next,   // enables as they stand after this cycle
    input  logic              rd_clear,
    output logic [DATA_W-1:0] flag_byte,
    output logic              irq
);
    irq_state_t       state, state_n;
    logic [EV_N-1:0]  flags, flags_n;
    logic             pending;

    assign flags_n = (rd_clear ? '0 : flags) | ev;
    assign pending = |(flags_n & en_next);

    always_comb begin
        state_n = state;
        unique case (state)
            IRQ_QUIET:  if (pending)       state_n = IRQ_RAISED;   // raise
            IRQ_RAISED: if (rd_clear && !pending) state_n = IRQ_QUIET; // acknowledge
            default:    state_n = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= IRQ_QUIET;
            flags <= '0;
        end else begin
            state <= state_n;
            flags <= flags_n;
        end
    end

    always_comb begin
        flag_byte = '0;
        flag_byte[FLG_SUM] = (state == IRQ_RAISED);
        flag_byte[EV_LSB +: EV_N] = flags;
        irq = (state == IRQ_RAISED);
    end

    p_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((flags & $past(ev)) == $past(ev)));
    p_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ev & en_next)) |=> irq);
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && ev == '0) |=> (flags == '0 && !irq));
    p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && ev != '0) |=> (flags == $past(ev)));
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int unsigned NUM_REGS = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic              host_port,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_hit,
    input  logic              tick_evt,
    input  logic              alarm_evt,
    input  logic              update_evt,
    input  logic              uip_in,
    output logic              irq
);
    logic [IDX_W-1:0]  idx;
    logic              in_range, data_wr, data_rd;
    logic [DATA_W-1:0] store_byte, ctrl, flag_byte;
    logic [EV_N-1:0]   en_next;
    logic              ctrl_wr, rd_clear;

    rtc_host_decode #(.NUM_REGS(NUM_REGS)) u_decode (
        .clk(clk), .rst_n(rst_n), .sel(host_sel), .wr(host_wr), .port(host_port),
        .wdata(host_wdata), .idx(idx), .in_range(in_range),
        .data_wr(data_wr), .data_rd(data_rd), .hit(host_hit)
    );

    rtc_reg_store #(.NUM_REGS(NUM_REGS)) u_store (
        .clk(clk), .rst_n(rst_n), .idx(idx), .data_wr(data_wr), .wdata(host_wdata),
        .uip_in(uip_in), .rd_byte(store_byte), .ctrl(ctrl)
    );

    assign ctrl_wr  = data_wr && idx == IDX_W'(IX_CTRL);
    assign rd_clear = data_rd && idx == IDX_W'(IX_FLAG);
    assign en_next  = ctrl_wr ? host_wdata[EV_LSB +: EV_N] : ctrl[EV_LSB +: EV_N];

    rtc_flag_fsm u_flags (
        .clk(clk), .rst_n(rst_n), .ev({tick_evt, alarm_evt, update_evt}),
        .en_next(en_next), .rd_clear(rd_clear), .flag_byte(flag_byte), .irq(irq)
    );

    always_comb begin
        if (!host_port || !in_range)      host_rdata = NO_DATA;
        else if (idx == IDX_W'(IX_FLAG))  host_rdata = flag_byte;
        else                              host_rdata = store_byte;
    end

    p_enable_latched_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && |(host_wdata[EV_LSB +: EV_N] & flag_byte[EV_LSB +: EV_N]) && !rd_clear) |=> irq);
    p_reset_24h_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq && ctrl[CTL_24H]));
endmodule

// File: tb/test_rtc_irq_ctrl.sv
`timescale 1ns/1ps
module test_rtc_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0, host_wr = 1'b0, host_port = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_hit;
    logic       tick_evt = 1'b0, alarm_evt = 1'b0, update_evt = 1'b0, uip_in = 1'b0;
    logic       irq;

    int n_tests = 0, n_fail = 0;
    logic       exp_rd[$];
    logic [7:0] exp_data[$];
    logic       exp_hit[$];
    string      exp_tag[$];

    always #4 clk = ~clk;

    rtc_irq_ctrl i_rtc_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_port(host_port), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_hit(host_hit), .tick_evt(tick_evt), .alarm_evt(alarm_evt),
        .update_evt(update_evt), .uip_in(uip_in), .irq(irq)
    );

    // monitor: pops one expected item per access
    always @(negedge clk) begin
        if (host_sel && exp_tag.size() > 0) begin
            logic r; logic [7:0] d; logic h; string t;
            r = exp_rd.pop_front(); d = exp_data.pop_front();
            h = exp_hit.pop_front(); t = exp_tag.pop_front();
            n_tests++;
            if (host_hit !== h || (r && host_rdata !== d)) begin
                n_fail++;
                $display("FAIL %s: rdata=%02h hit=%0b expected rdata=%02h hit=%0b",
                         t, host_rdata, host_hit, d, h);
            end
        end
    end

    task automatic access(input logic wr, input logic port, input logic [7:0] wd,
                          input logic [7:0] ev, input logic [7:0] exp_d,
                          input logic exp_h, input string tag);
        @(posedge clk); #1;
        exp_rd.push_back(!wr); exp_data.push_back(exp_d);
        exp_hit.push_back(exp_h); exp_tag.push_back(tag);
        host_sel = 1'b1; host_wr = wr; host_port = port; host_wdata = wd;
        {tick_evt, alarm_evt, update_evt} = ev[2:0];
        @(posedge clk); #1;
        host_sel = 1'b0; {tick_evt, alarm_evt, update_evt} = 3'b000;
    endtask

    task automatic pulse(input logic [2:0] ev);
        @(posedge clk); #1;
        {tick_evt, alarm_evt, update_evt} = ev;
        @(posedge clk); #1;
        {tick_evt, alarm_evt, update_evt} = 3'b000;
    endtask

    task automatic set_idx(input logic [7:0] v, input string tag);
        access(1'b1, 1'b0, v, 8'h0, 8'h0, (v[6:0] < 7'd14), tag);
    endtask
    task automatic rd(input logic [7:0] i, input logic [7:0] exp, input string tag);
        set_idx(i, tag);
        access(1'b0, 1'b1, 8'h0, 8'h0, exp, 1'b1, tag);
    endtask
    task automatic wrr(input logic [7:0] i, input logic [7:0] v, input string tag);
        set_idx(i, tag);
        access(1'b1, 1'b1, v, 8'h0, 8'h0, 1'b1, tag);
    endtask
    task automatic chk_irq(input logic exp, input string tag);
        n_tests++;
        if (irq !== exp) begin
            n_fail++;
            $display("FAIL %s: irq=%0b expected=%0b", tag, irq, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk_irq(1'b0, "R1 irq after reset");
        rd(8'd10, 8'h26, "R1 rate");
        rd(8'd11, 8'h02, "R1 control");
        rd(8'd12, 8'h00, "R1 flags");
        rd(8'd13, 8'h80, "R1 status D");
        // R2 index masking and index-port read
        set_idx(8'h8B, "R2 index write high bit");
        access(1'b0, 1'b1, 8'h0, 8'h0, 8'h02, 1'b1, "R2 masked index selects control");
        access(1'b0, 1'b0, 8'h0, 8'h0, 8'hFF, 1'b1, "R2 index port read");
        // R11 plain storage
        wrr(8'd3, 8'hA5, "R11 write");
        rd(8'd3, 8'hA5, "R11 readback");
        // R3 out of range
        set_idx(8'h0E, "R3 index write out of range");
        access(1'b1, 1'b1, 8'h5A, 8'h0, 8'h0, 1'b0, "R3 data write not handled");
        access(1'b0, 1'b1, 8'h0, 8'h0, 8'hFF, 1'b0, "R3 data read not handled");
        rd(8'd3, 8'hA5, "R3 storage untouched");
        // R4 latch while masked
        pulse(3'b100);
        chk_irq(1'b0, "R4 masked tick no irq");
        rd(8'd12, 8'h40, "R4 periodic flag");
        rd(8'd12, 8'h00, "R6 cleared after read");
        pulse(3'b011);
        chk_irq(1'b0, "R4 masked alarm/update no irq");
        rd(8'd12, 8'h30, "R4 alarm and update flags");
        // R5 enabled raise, R6 clear
        wrr(8'd11, 8'h22, "R5 enable alarm");
        chk_irq(1'b0, "R5 no flag yet");
        pulse(3'b010);
        chk_irq(1'b1, "R5 irq after alarm");
        rd(8'd12, 8'hA0, "R5 summary and alarm");
        chk_irq(1'b0, "R6 irq dropped by read");
        rd(8'd12, 8'h00, "R6 flags zero");
        // R8 enable with latched flag
        wrr(8'd11, 8'h02, "R8 mask all");
        pulse(3'b001);
        chk_irq(1'b0, "R8 masked update");
        set_idx(8'd11, "R8 index");
        access(1'b1, 1'b1, 8'h12, 8'h0, 8'h0, 1'b1, "R8 enable update");
        chk_irq(1'b1, "R8 irq at enabling write");
        rd(8'd12, 8'h90, "R8 summary and update");
        chk_irq(1'b0, "R8 cleared");
        // R7 read-only bytes
        pulse(3'b100);
        wrr(8'd12, 8'hFF, "R7 write flags");
        rd(8'd12, 8'h40, "R7 flags unchanged");
        wrr(8'd13, 8'h00, "R7 write status D");
        rd(8'd13, 8'h80, "R7 status D unchanged");
        // R9 rate update-in-progress bit
        wrr(8'd10, 8'hFF, "R9 write rate");
        rd(8'd10, 8'h7F, "R9 bit7 kept clear");
        uip_in = 1'b1;
        wrr(8'd10, 8'h00, "R9 write rate zero");
        rd(8'd10, 8'h80, "R9 bit7 follows status");
        uip_in = 1'b0;
        // R10 event during read-clear
        wrr(8'd11, 8'h42, "R10 enable periodic");
        pulse(3'b010);
        chk_irq(1'b0, "R10 alarm masked");
        set_idx(8'd12, "R10 index");
        access(1'b0, 1'b1, 8'h0, 8'h04, 8'h20, 1'b1, "R10 read returns old flags");
        chk_irq(1'b1, "R10 new tick raises irq");
        rd(8'd12, 8'hC0, "R10 tick flag survives clear");
        chk_irq(1'b0, "R10 cleared");
        repeat (3) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule